// File: doc/BRIEF.md
# Byte-Port Serial Register Front End

This block is the bus-side register face of a simple serial port. A host reaches three word-wide registers through single-cycle memory-mapped reads and writes: a transmit data register, a receive holding register and a status register. On the line side, received bytes arrive and transmitted bytes leave over ready/valid byte handshakes. Baud-rate timing and bit serialisation are assumed to sit behind those handshakes.

The receive path holds exactly one byte. While that byte is unread, the line side is back-pressured. A bus read of the receive register returns the byte and frees the slot in the same access. The transmit path has no storage: an accepted write passes its low byte straight to the line side in the cycle of the write. Writes to the status register, accesses that are not a full aligned word, and offsets that no register occupies all leave every piece of state untouched. Such reads return zero.

Top module: `serport_regif`

## Requirements
- R1: After reset the receive holding register is zero, the receive flag is clear (`rx_ready` high), `bus_rdata` is zero and `tx_valid` is low; a status read then returns 0x2 while `tx_ready` is high.
- R2: A status read (byte offset 0x08) returns the receive-full flag in bit 0, the current level of `tx_ready` in bit 1, and zero in bits 31:2.
- R3: While the receive flag is set, `rx_ready` is low and a byte offered on `rx_byte`/`rx_valid` is not taken: the held byte and the flag stay as they were.
- R4: A byte offered while the flag is clear is taken at that clock edge; the byte is loaded into the holding register and the flag is set.
- R5: A read of the receive register (offset 0x04) returns the held byte in bits 7:0 with bits 31:8 zero, and clears the flag at the same edge; if a new byte is taken in that same cycle, the new byte and a set flag win.
- R6: A write to the transmit register (offset 0x00) while `tx_ready` is high raises `tx_valid` in that same cycle with `tx_byte` equal to `bus_wdata[7:0]`; a write while `tx_ready` is low is dropped; a read of offset 0x00 returns zero.
- R7: Writes to the status register change nothing.
- R8: Only an access with all four byte enables set and `bus_addr[1:0]` equal to 0 takes effect; any other read returns zero and clears no flag, and any other write is discarded.
- R9: The window is 0x18 bytes. Word offsets 0x0C, 0x10 and 0x14, and addresses at or above 0x18, read as zero and ignore writes.
- R10: `bus_rdata` is registered: it is loaded at the clock edge that ends a read cycle and holds its value through cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address within the window |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one edge after the read |
| rx_byte | input | 8 | Byte from the line side |
| rx_valid | input | 1 | Line side offers `rx_byte` |
| rx_ready | output | 1 | Holding register is free |
| tx_byte | output | 8 | Byte to the line side |
| tx_valid | output | 1 | Transmit byte present this cycle |
| tx_ready | input | 1 | Line side can take a byte |

## Verification
`tx_valid` and `tx_byte` are combinational from the bus write, so the bench samples them one nanosecond after it drives the access, before the edge. `bus_rdata` and the receive flag change at the single edge inside an access or offer cycle, so the bench samples them at the following falling edge. The effect of every offer, clear or ignored write is confirmed afterwards by a later status or receive read. That read sees the state as it stands after exactly one edge.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int DATA_W    = 32;
  localparam int BYTE_W    = 8;
  localparam int BUS_BYTES = DATA_W / BYTE_W;
  localparam int NUM_REGS  = 3;

  localparam int IDX_TX = 0;
  localparam int IDX_RX = 1;
  localparam int IDX_ST = 2;

  localparam int ST_RXFULL_BIT = 0;
  localparam int ST_TXRDY_BIT  = 1;

  typedef struct packed {
    logic tx;
    logic rx;
    logic st;
  } hit_t;

  // full aligned word only
  function automatic logic access_ok(input logic [BUS_BYTES-1:0] be,
                                     input logic [1:0] lo);
    return (be == {BUS_BYTES{1'b1}}) && (lo == 2'b00);
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic rx_full,
                                                    input logic tx_rdy);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ST_RXFULL_BIT] = rx_full;
    w[ST_TXRDY_BIT]  = tx_rdy;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] byte_word(input logic [BYTE_W-1:0] b);
    return {{(DATA_W-BYTE_W){1'b0}}, b};
  endfunction
endpackage

// File: rtl/serport_decode.sv
module serport_decode
  import serport_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BYTES = 24
) (
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_BYTES-1:0] bus_be,
  output hit_t                 rd_hit,
  output hit_t                 wr_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic             legal;
  logic [IDX_W-1:0] idx;
  logic [NUM_REGS-1:0] sel_vec;

  always_comb begin
    idx   = bus_addr[ADDR_W-1:2];
    legal = bus_sel && access_ok(bus_be, bus_addr[1:0]) &&
            (32'(bus_addr) < 32'(WIN_BYTES));
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
    assign sel_vec[g] = legal && (idx == IDX_W'(g));
  end

  always_comb begin
    rd_hit.tx = sel_vec[IDX_TX] && !bus_wr;
    rd_hit.rx = sel_vec[IDX_RX] && !bus_wr;
    rd_hit.st = sel_vec[IDX_ST] && !bus_wr;
    wr_hit.tx = sel_vec[IDX_TX] && bus_wr;
    wr_hit.rx = sel_vec[IDX_RX] && bus_wr;
    wr_hit.st = sel_vec[IDX_ST] && bus_wr;
  end
endmodule

// File: rtl/serport_rxhold.sv
module serport_rxhold
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              clr,
  output logic [BYTE_W-1:0] hold_q,
  output logic              full_q
);
  logic accept;

  assign rx_ready = !full_q;
  assign accept   = rx_valid && rx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      hold_q <= rx_byte;
      full_q <= 1'b1;
    end else if (clr) begin
      full_q <= 1'b0;
    end
  end

  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (full_q && hold_q == $past(rx_byte))); // R4
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> !full_q); // R5
  AST_RX_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !clr) |=> (full_q && $stable(hold_q))); // R3
endmodule

// File: rtl/serport_rdmux.sv
module serport_rdmux
  import serport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_any,
  input  hit_t              rd_hit,
  input  logic [BYTE_W-1:0] hold_q,
  input  logic              full_q,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] rdata_q
);
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    if (rd_hit.st)      rd_word = status_word(full_q, tx_ready);
    else if (rd_hit.rx) rd_word = byte_word(hold_q);
    else                rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_any) rdata_q <= rd_word;
  end

  AST_ST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit.st |=> (rdata_q[DATA_W-1:2] == '0)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> $stable(rdata_q)); // R10
endmodule

// File: rtl/serport_regif.sv
module serport_regif
  import serport_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int WIN_BYTES = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_BYTES-1:0] bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [BYTE_W-1:0]    rx_byte,
  input  logic                 rx_valid,
  output logic                 rx_ready,
  output logic [BYTE_W-1:0]    tx_byte,
  output logic                 tx_valid,
  input  logic                 tx_ready
);
  hit_t              rd_hit;
  hit_t              wr_hit;
  logic              rd_any;
  logic [BYTE_W-1:0] hold_q;
  logic              full_q;
  logic              unused_bits;

  serport_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .bus_be  (bus_be),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit)
  );

  serport_rxhold u_rxhold (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_byte (rx_byte),
    .rx_valid(rx_valid),
    .rx_ready(rx_ready),
    .clr     (rd_hit.rx),
    .hold_q  (hold_q),
    .full_q  (full_q)
  );

  assign rd_any = bus_sel && !bus_wr;

  serport_rdmux u_rdmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_any  (rd_any),
    .rd_hit  (rd_hit),
    .hold_q  (hold_q),
    .full_q  (full_q),
    .tx_ready(tx_ready),
    .rdata_q (bus_rdata)
  );

  // transmit passes straight through; no storage
  assign tx_valid = wr_hit.tx && tx_ready;
  assign tx_byte  = bus_wdata[BYTE_W-1:0];

  // status and receive writes have no target
  assign unused_bits = ^{bus_wdata[DATA_W-1:BYTE_W], wr_hit.rx, wr_hit.st};

  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> !tx_valid); // R6
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !(rd_hit.tx || rd_hit.rx || rd_hit.st)) |=> (bus_rdata == '0)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_hit.tx, rd_hit.rx, rd_hit.st, wr_hit.tx, wr_hit.rx, wr_hit.st})); // R9
endmodule

// File: tb/serport_regif_bench.sv
`timescale 1ns/1ps
module serport_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        tx_ready = 1'b1;

  int tests = 0, fails = 0;
  logic        txv_s;
  logic [7:0]  txb_s;
  logic [31:0] rd_s;
  logic        rdy_s;

  always #2 clk = ~clk;

  serport_regif u_serport_regif (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready)
  );

  // {wr, addr[5], be[4], wdata[32], expect[32], exp_txv}
  localparam logic [74:0] VEC [12] = '{
    {1'b0, 5'h08, 4'hF, 32'h0,         32'h2,  1'b0}, // R2 status after reset
    {1'b0, 5'h00, 4'hF, 32'h0,         32'h0,  1'b0}, // R6 tx reads zero
    {1'b0, 5'h04, 4'hF, 32'h0,         32'h0,  1'b0}, // R1 hold is zero
    {1'b1, 5'h08, 4'hF, 32'hFFFF_FFFF, 32'h0,  1'b0}, // R7 status write
    {1'b0, 5'h08, 4'hF, 32'h0,         32'h2,  1'b0}, // R7 status unchanged
    {1'b0, 5'h0C, 4'hF, 32'h0,         32'h0,  1'b0}, // R9 hole
    {1'b0, 5'h14, 4'hF, 32'h0,         32'h0,  1'b0}, // R9 last word
    {1'b0, 5'h1C, 4'hF, 32'h0,         32'h0,  1'b0}, // R9 past window
    {1'b1, 5'h00, 4'hF, 32'h1234_56A5, 32'hA5, 1'b1}, // R6 send
    {1'b1, 5'h00, 4'h1, 32'h0000_0011, 32'h0,  1'b0}, // R8 partial enables
    {1'b1, 5'h02, 4'hF, 32'h0000_0022, 32'h0,  1'b0}, // R8 misaligned
    {1'b1, 5'h10, 4'hF, 32'h0000_0033, 32'h0,  1'b0}  // R9 unmapped write
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [4:0] a, input logic [3:0] be,
                     input logic [31:0] wd);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
    #1;
    txv_s = tx_valid; txb_s = tx_byte;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd_s = bus_rdata;
  endtask

  task automatic offer(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    #1;
    rdy_s = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h1);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      logic [74:0] v;
      v = VEC[i];
      bus(v[74], v[73:69], v[68:65], v[64:33]);
      if (v[74]) begin
        chk($sformatf("table row %0d tx_valid", i), {31'h0, txv_s}, {31'h0, v[0]});
        if (v[0]) chk($sformatf("table row %0d tx_byte", i), {24'h0, txb_s}, v[32:1]);
      end else begin
        chk($sformatf("table row %0d rdata", i), rd_s, v[32:1]);
      end
    end

    // R4 load into free slot
    offer(8'h5A);
    chk("R4 ready before load", {31'h0, rdy_s}, 32'h1);
    bus(1'b0, 5'h08, 4'hF, 32'h0);
    chk("R4 status full", rd_s, 32'h3);
    // R3 back-pressure while full
    offer(8'hC3);
    chk("R3 ready low when full", {31'h0, rdy_s}, 32'h0);
    // R8 misaligned read returns zero and clears nothing
    bus(1'b0, 5'h05, 4'hF, 32'h0);
    chk("R8 misaligned read", rd_s, 32'h0);
    bus(1'b0, 5'h04, 4'h3, 32'h0);
    chk("R8 partial read", rd_s, 32'h0);
    // R7 status write does not clear flag
    bus(1'b1, 5'h08, 4'hF, 32'h0);
    bus(1'b0, 5'h08, 4'hF, 32'h0);
    chk("R7 flag kept", rd_s, 32'h3);
    // R5 read returns held byte (not the refused one) and clears
    bus(1'b0, 5'h04, 4'hF, 32'h0);
    chk("R5 rx read byte", rd_s, 32'h5A);
    bus(1'b0, 5'h08, 4'hF, 32'h0);
    chk("R5 flag cleared", rd_s, 32'h2);
    // R10 rdata holds through idle cycles
    repeat (3) @(negedge clk);
    chk("R10 rdata held", bus_rdata, 32'h2);
    // R5 simultaneous read and accept: new byte wins
    rx_valid = 1'b1; rx_byte = 8'h77;
    bus(1'b0, 5'h04, 4'hF, 32'h0);
    rx_valid = 1'b0;
    chk("R5 same-cycle read old byte", rd_s, 32'h5A);
    bus(1'b0, 5'h08, 4'hF, 32'h0);
    chk("R5 same-cycle flag set", rd_s, 32'h3);
    bus(1'b0, 5'h04, 4'hF, 32'h0);
    chk("R5 same-cycle new byte", rd_s, 32'h77);
    // R6 write dropped while tx_ready low; R2 bit 1 follows tx_ready
    tx_ready = 1'b0;
    bus(1'b1, 5'h00, 4'hF, 32'h99);
    chk("R6 dropped write", {31'h0, txv_s}, 32'h0);
    bus(1'b0, 5'h08, 4'hF, 32'h0);
    chk("R2 tx bit low", rd_s, 32'h0);
    tx_ready = 1'b1;
    // R1 reset while full
    offer(8'hE1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 rx_ready after reset", {31'h0, rx_ready}, 32'h1);
    bus(1'b0, 5'h08, 4'hF, 32'h0);
    chk("R1 status after reset", rd_s, 32'h2);
    bus(1'b0, 5'h04, 4'hF, 32'h0);
    chk("R1 hold after reset", rd_s, 32'h0);

    finish_run();
  end
endmodule